// File: doc/BRIEF.md
# Display Interrupt Status Aggregator

This block gathers the event flags of a seven-channel display controller into two sticky status words and drives a single interrupt line toward the system interrupt controller. The fetch engines report start-of-frame, end-of-frame, branch-taken, input-underrun, bus-error and last-frame-done events. Each report is a one-cycle pulse that carries a kind code, a channel number, the frame ID of the descriptor in use, and copies of that descriptor's two interrupt-enable command bits (bit 22 for start-of-frame, bit 21 for end-of-frame).

Channel 0 reports into the primary status word. Its masks sit in the upper half of the primary control word. Channels 1 to 6 report into the secondary status word, which is laid out as four six-bit groups. A secondary mask word uses the same bit positions. Software reads every register through a small register port and clears status bits by writing ones. When an unmasked event arrives while the line is low, the frame ID of that event is latched for software to read. If the line is already high, a subsequent-interrupt flag is set instead, and the latched ID stays as it was.

Top module: `disp_irq_agg`

## Requirements
- R1: The register addresses are 0 control, 1 secondary mask, 2 primary status, 3 secondary status and 4 latched frame ID. Any other address reads zero. After reset every register reads zero and the interrupt line is low.
- R2: The event kind codes are 1 last-frame-done, 2 start-of-frame, 3 end-of-frame, 4 branch, 5 underrun and 6 bus error. Last-frame-done sets primary bit 0. For channel 0, start-of-frame sets primary bit 1, underrun sets bit 4, end-of-frame sets bit 8 and branch sets bit 9. For a channel ch from 1 to 6, start-of-frame sets secondary bit ch-1, end-of-frame sets bit ch+7, branch sets bit ch+15 and underrun sets bit ch+23.
- R3: A start-of-frame event is recorded only when its command bit 22 copy is high. An end-of-frame event is recorded only when its command bit 21 copy is high. A rejected event changes neither status nor the latched ID.
- R4: The interrupt line is a register that follows the status and mask state of the previous cycle. It is high when any of the following holds:
  - primary bit k, for k in {0,1,4,7,8,9}, is set while control bit 16+k is clear;
  - primary bit 2 is set;
  - a secondary bit is set while its mask bit is clear.
  Bit 10 does not drive the line.
- R5: Take an unmasked start-of-frame, end-of-frame or branch event, or any bus error, that arrives while the line is low. Such an event loads its frame ID into the ID register. A masked event sets its status bit but leaves the ID alone.
- R6: The same qualifying event, arriving while the line is high, sets primary bit 10 and leaves the ID unchanged.
- R7: A bus error on channel 0 to 6 sets primary bit 2 whatever the masks hold. It also ORs the channel number into primary bits 30:28.
- R8: Writing the primary status word clears each set bit of the written value's bits 11:0. When written bit 2 is one, bits 30:28 are cleared as well.
- R9: Writing the secondary status word clears only the bits under 0x003E3F3F. The underrun bits and the channel-1 branch bit can be cleared only by reset.
- R10: A control write that turns bit 0 from one to zero sets primary bit 7.
- R11: When an event sets a status bit in the same cycle as a write that clears it, the bit ends up set.
- R12: Per-channel events that name a channel above 6 are ignored. Underrun and last-frame-done events never touch the ID register or bit 10.
- R13: The control register stores only the bits under 0x03930001. The secondary mask register stores only the bits under 0x3F3F3F3F. The ID register cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ev_valid_i | input | 1 | Event pulse qualifier |
| ev_kind_i | input | 3 | Event kind code (R2) |
| ev_ch_i | input | CH_W (3) | Channel that raised the event |
| ev_sof_ie_i | input | 1 | Copy of the channel command word's start-of-frame enable (bit 22) |
| ev_eof_ie_i | input | 1 | Copy of the channel command word's end-of-frame enable (bit 21) |
| ev_id_i | input | ID_W (32) | Frame ID of the channel's current descriptor |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench probes the decision between capturing the ID and setting the subsequent flag. It fires events just before and just after the registered line rises, which exposes a design that samples the next line value instead of the current one: such a design overwrites the ID one cycle too late or too early. It sets events and clears of the same bit in the same cycle, where a design that gives the clear priority loses the event. It writes all ones to the secondary word, which catches a design that clears the underrun and channel-1 branch bits. It also sends bus errors under full masking, so a design that masks errors leaves the line low and the channel field empty. Finally, it drives start-of-frame and end-of-frame events with their enable copies low and events on channel 7, which a design lacking those filters would record.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

    localparam int NCH_DEF  = 7;
    localparam int DW       = 32;
    localparam int AW       = 3;

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_FDONE  = 3'd1,
        EV_SOF    = 3'd2,
        EV_EOF    = 3'd3,
        EV_BRANCH = 3'd4,
        EV_UNDER  = 3'd5,
        EV_BUSERR = 3'd6
    } ev_kind_e;

    typedef enum logic [AW-1:0] {
        RA_CTRL  = 3'd0,
        RA_SMASK = 3'd1,
        RA_STAT0 = 3'd2,
        RA_STAT1 = 3'd3,
        RA_IRQID = 3'd4
    } reg_addr_e;

    // primary status bit positions
    localparam int B_FDONE   = 0;
    localparam int B_SOF0    = 1;
    localparam int B_BERR    = 2;
    localparam int B_UNDER0  = 4;
    localparam int B_QDONE   = 7;
    localparam int B_EOF0    = 8;
    localparam int B_BRANCH0 = 9;
    localparam int B_SINT    = 10;
    localparam int B_BCH_LO  = 28;
    localparam int BCH_W     = 3;

    localparam int MASK_OFS  = 16;

    localparam logic [DW-1:0] MASKABLE0  = (DW'(1) << B_FDONE)  | (DW'(1) << B_SOF0)
                                         | (DW'(1) << B_UNDER0) | (DW'(1) << B_QDONE)
                                         | (DW'(1) << B_EOF0)   | (DW'(1) << B_BRANCH0);
    localparam logic [DW-1:0] CTRL_WMASK  = DW'(1) | (MASKABLE0 << MASK_OFS);
    localparam logic [DW-1:0] SMASK_WMASK = 32'h3F3F_3F3F;
    localparam logic [DW-1:0] STAT0_CLR   = 32'h0000_0FFF;
    localparam logic [DW-1:0] STAT1_CLR   = 32'h003E_3F3F;
    localparam logic [DW-1:0] BCH_FIELD   = ((DW'(1) << BCH_W) - 1) << B_BCH_LO;

    typedef struct packed {
        logic [DW-1:0] set0;
        logic [DW-1:0] set1;
        logic          capture;
    } ev_effect_t;

    function automatic int prim_bit(ev_kind_e k);
        case (k)
            EV_SOF:    return B_SOF0;
            EV_EOF:    return B_EOF0;
            EV_BRANCH: return B_BRANCH0;
            default:   return B_UNDER0;
        endcase
    endfunction

    // bit of channel 1 within each secondary group
    function automatic int sec_base(ev_kind_e k);
        case (k)
            EV_SOF:    return 0;
            EV_EOF:    return 8;
            EV_BRANCH: return 16;
            default:   return 24;
        endcase
    endfunction

endpackage

// File: rtl/disp_irq_decode.sv
module disp_irq_decode
    import disp_irq_pkg::*;
#(
    parameter int NUM_CH = NCH_DEF,
    parameter int CH_W   = 3
) (
    input  logic                ev_valid,
    input  ev_kind_e            ev_kind,
    input  logic [CH_W-1:0]     ev_ch,
    input  logic                sof_ie,
    input  logic                eof_ie,
    input  logic [DW-1:0]       ctrl0,
    input  logic [DW-1:0]       mask1,
    output ev_effect_t          eff
);

    always_comb begin
        int  pb;
        int  sb;
        logic allowed;
        logic unmasked;
        eff      = '0;
        pb       = prim_bit(ev_kind);
        sb       = sec_base(ev_kind) + int'(ev_ch) - 1;
        allowed  = 1'b0;
        unmasked = 1'b0;
        if (ev_valid) begin
            if (ev_kind == EV_FDONE) begin
                eff.set0[B_FDONE] = 1'b1;
            end else if (int'(ev_ch) < NUM_CH) begin
                if (ev_kind == EV_BUSERR) begin
                    eff.set0[B_BERR]             = 1'b1;
                    eff.set0[B_BCH_LO +: BCH_W]  = BCH_W'(ev_ch);
                    eff.capture                  = 1'b1;
                end else if (ev_kind != EV_NONE) begin
                    case (ev_kind)
                        EV_SOF:  allowed = sof_ie;
                        EV_EOF:  allowed = eof_ie;
                        default: allowed = 1'b1;
                    endcase
                    if (allowed) begin
                        if (ev_ch == '0) begin
                            eff.set0[pb] = 1'b1;
                            unmasked     = !ctrl0[MASK_OFS + pb];
                        end else begin
                            eff.set1[sb] = 1'b1;
                            unmasked     = !mask1[sb];
                        end
                        eff.capture = unmasked && (ev_kind != EV_UNDER);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
    import disp_irq_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   ctrl0_q,
    output logic [DW-1:0]   mask1_q,
    output logic            qdone_set
);

    logic ctrl_wr;
    logic mask_wr;

    assign ctrl_wr   = we && (reg_addr_e'(addr) == RA_CTRL);
    assign mask_wr   = we && (reg_addr_e'(addr) == RA_SMASK);
    assign qdone_set = ctrl_wr && ctrl0_q[0] && !wdata[0];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl0_q <= '0;
            mask1_q <= '0;
        end else begin
            if (ctrl_wr) ctrl0_q <= wdata & CTRL_WMASK;
            if (mask_wr) mask1_q <= wdata & SMASK_WMASK;
        end
    end

endmodule

// File: rtl/disp_irq_line.sv
module disp_irq_line
    import disp_irq_pkg::*;
#(
    parameter int NUM_CH = NCH_DEF
) (
    input  logic [DW-1:0] st0,
    input  logic [DW-1:0] st1,
    input  logic [DW-1:0] ctrl0,
    input  logic [DW-1:0] mask1,
    output logic          level
);

    localparam int NSEC = NUM_CH - 1;

    logic [NSEC-1:0] sec_hit;
    logic            prim_hit;

    assign prim_hit = |(st0 & MASKABLE0 & ~(ctrl0 >> MASK_OFS)) | st0[B_BERR];

    for (genvar g = 0; g < NSEC; g++) begin : g_sec
        logic [3:0] grp;
        for (genvar q = 0; q < 4; q++) begin : g_grp
            assign grp[q] = st1[8*q + g] && !mask1[8*q + g];
        end
        assign sec_hit[g] = |grp;
    end

    assign level = prim_hit | (|sec_hit);

endmodule

// File: rtl/disp_irq_agg.sv
module disp_irq_agg
    import disp_irq_pkg::*;
#(
    parameter int NUM_CH = NCH_DEF,
    parameter int ID_W   = 32,
    localparam int CH_W  = $clog2(NUM_CH + 1)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                ev_valid_i,
    input  logic [2:0]          ev_kind_i,
    input  logic [CH_W-1:0]     ev_ch_i,
    input  logic                ev_sof_ie_i,
    input  logic                ev_eof_ie_i,
    input  logic [ID_W-1:0]     ev_id_i,
    input  logic                reg_we_i,
    input  logic [AW-1:0]       reg_addr_i,
    input  logic [DW-1:0]       reg_wdata_i,
    output logic [DW-1:0]       reg_rdata_o,
    output logic                irq_o
);

    logic [DW-1:0]   ctrl0_q;
    logic [DW-1:0]   mask1_q;
    logic [DW-1:0]   st0_q;
    logic [DW-1:0]   st1_q;
    logic [ID_W-1:0] id_q;
    logic            irq_q;
    logic            qdone_set;
    logic            line_d;
    logic            ev_capture;
    ev_effect_t      eff;
    logic [DW-1:0]   clr0;
    logic [DW-1:0]   clr1;
    logic [DW-1:0]   sint_set;

    disp_irq_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .we        (reg_we_i),
        .addr      (reg_addr_i),
        .wdata     (reg_wdata_i),
        .ctrl0_q   (ctrl0_q),
        .mask1_q   (mask1_q),
        .qdone_set (qdone_set)
    );

    disp_irq_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
        .ev_valid (ev_valid_i),
        .ev_kind  (ev_kind_e'(ev_kind_i)),
        .ev_ch    (ev_ch_i),
        .sof_ie   (ev_sof_ie_i),
        .eof_ie   (ev_eof_ie_i),
        .ctrl0    (ctrl0_q),
        .mask1    (mask1_q),
        .eff      (eff)
    );

    disp_irq_line #(.NUM_CH(NUM_CH)) u_line (
        .st0   (st0_q),
        .st1   (st1_q),
        .ctrl0 (ctrl0_q),
        .mask1 (mask1_q),
        .level (line_d)
    );

    assign ev_capture = eff.capture;

    always_comb begin
        clr0 = '0;
        clr1 = '0;
        if (reg_we_i && reg_addr_e'(reg_addr_i) == RA_STAT0) begin
            clr0 = reg_wdata_i & STAT0_CLR;
            if (reg_wdata_i[B_BERR]) clr0 = clr0 | BCH_FIELD;
        end
        if (reg_we_i && reg_addr_e'(reg_addr_i) == RA_STAT1) begin
            clr1 = reg_wdata_i & STAT1_CLR;
        end
        sint_set = (ev_capture && irq_q) ? (DW'(1) << B_SINT) : '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st0_q <= '0;
            st1_q <= '0;
            id_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            // set terms follow the clear so a same-cycle event survives
            st0_q <= (st0_q & ~clr0) | eff.set0 | sint_set
                   | (qdone_set ? (DW'(1) << B_QDONE) : '0);
            st1_q <= (st1_q & ~clr1) | eff.set1;
            if (ev_capture && !irq_q) id_q <= ev_id_i;
            irq_q <= line_d;
        end
    end

    always_comb begin
        case (reg_addr_e'(reg_addr_i))
            RA_CTRL:  reg_rdata_o = ctrl0_q;
            RA_SMASK: reg_rdata_o = mask1_q;
            RA_STAT0: reg_rdata_o = st0_q;
            RA_STAT1: reg_rdata_o = st1_q;
            RA_IRQID: reg_rdata_o = DW'(id_q);
            default:  reg_rdata_o = '0;
        endcase
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/disp_irq_agg_chk.sv
module disp_irq_agg_chk
    import disp_irq_pkg::*;
#(
    parameter int NUM_CH = NCH_DEF,
    parameter int ID_W   = 32,
    parameter int CH_W   = 3
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                ev_valid_i,
    input logic [2:0]          ev_kind_i,
    input logic [CH_W-1:0]     ev_ch_i,
    input logic [ID_W-1:0]     ev_id_i,
    input logic                reg_we_i,
    input logic [AW-1:0]       reg_addr_i,
    input logic [DW-1:0]       reg_wdata_i,
    input logic                irq_o,
    input logic                ev_capture,
    input logic [DW-1:0]       st0_q,
    input logic [DW-1:0]       st1_q,
    input logic [DW-1:0]       ctrl0_q,
    input logic [ID_W-1:0]     id_q
);

    p_buserr_field_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_valid_i && ev_kind_i == 3'd6 && int'(ev_ch_i) < NUM_CH)
        |=> (st0_q[B_BERR] &&
             ((st0_q[B_BCH_LO +: BCH_W] & BCH_W'($past(ev_ch_i))) == BCH_W'($past(ev_ch_i)))));

    p_id_load_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_capture && !irq_o) |=> (id_q == $past(ev_id_i)));

    p_sint_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_capture && irq_o) |=> (st0_q[B_SINT] && $stable(id_q)));

    p_qdone_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_we_i && reg_addr_i == 3'd0 && ctrl0_q[0] && !reg_wdata_i[0])
        |=> st0_q[B_QDONE]);

    p_under_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (st1_q[29:24] != 6'd0) |=> (($past(st1_q[29:24]) & ~st1_q[29:24]) == 6'd0));

    p_berr_drives_line_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        st0_q[B_BERR] |=> irq_o);

endmodule

bind disp_irq_agg disp_irq_agg_chk #(.NUM_CH(NUM_CH), .ID_W(ID_W), .CH_W(CH_W)) chk_i (.*);

// File: tb/disp_irq_agg_tb_top.sv
`timescale 1ns/1ps
module disp_irq_agg_tb_top;

    localparam int KFD = 1, KSOF = 2, KEOF = 3, KBR = 4, KUN = 5, KBER = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        ev_valid;
    logic [2:0]  ev_kind;
    logic [2:0]  ev_ch;
    logic        ev_sof_ie;
    logic        ev_eof_ie;
    logic [31:0] ev_id;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    logic [31:0] m_ctrl, m_mask, m_st0, m_st1, m_id;
    bit          m_irq;

    always #5 clk = ~clk;

    disp_irq_agg dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .ev_valid_i  (ev_valid),
        .ev_kind_i   (ev_kind),
        .ev_ch_i     (ev_ch),
        .ev_sof_ie_i (ev_sof_ie),
        .ev_eof_ie_i (ev_eof_ie),
        .ev_id_i     (ev_id),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    function automatic bit model_line();
        bit l = 0;
        int prim[6] = '{0, 1, 4, 7, 8, 9};
        foreach (prim[i]) if (m_st0[prim[i]] && !m_ctrl[16 + prim[i]]) l = 1;
        if (m_st0[2]) l = 1;
        for (int i = 0; i < 32; i++) if (m_st1[i] && !m_mask[i]) l = 1;
        return l;
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] exp;
        string nm;
        for (int a = 0; a < 6; a++) begin
            reg_addr = a[2:0];
            #1;
            case (a)
                0: begin exp = m_ctrl; nm = "ctrl"; end
                1: begin exp = m_mask; nm = "smask"; end
                2: begin exp = m_st0;  nm = "stat0"; end
                3: begin exp = m_st1;  nm = "stat1"; end
                4: begin exp = m_id;   nm = "id"; end
                default: begin exp = 0; nm = "unused addr"; end
            endcase
            check(reg_rdata === exp, nm, reg_rdata, exp);
        end
        check(irq === m_irq, "irq line", {31'd0, irq}, {31'd0, m_irq});
    endtask

    task automatic step(input bit v, input int k, input int ch, input bit sie, input bit eie,
                        input logic [31:0] id, input bit we, input int a, input logic [31:0] wd);
        logic [31:0] n0, n1, nc, nm, ni;
        bit nirq, unm, cap, ok;
        int pb, sb;
        ev_valid = v; ev_kind = k[2:0]; ev_ch = ch[2:0]; ev_sof_ie = sie; ev_eof_ie = eie;
        ev_id = id; reg_we = we; reg_addr = a[2:0]; reg_wdata = wd;
        nirq = model_line();
        n0 = m_st0; n1 = m_st1; nc = m_ctrl; nm = m_mask; ni = m_id;
        if (we && a == 2) begin
            n0 = n0 & ~(wd & 32'hFFF);
            if (wd[2]) n0[30:28] = 3'd0;
        end
        if (we && a == 3) n1 = n1 & ~(wd & 32'h003E3F3F);
        if (we && a == 0) begin
            if (m_ctrl[0] && !wd[0]) n0[7] = 1'b1;
            nc = wd & 32'h0393_0001;
        end
        if (we && a == 1) nm = wd & 32'h3F3F3F3F;
        cap = 0;
        if (v) begin
            if (k == KFD) n0[0] = 1'b1;
            else if (ch <= 6 && k == KBER) begin
                n0[2] = 1'b1;
                n0[30:28] = n0[30:28] | ch[2:0];
                cap = 1;
            end else if (ch <= 6 && k >= KSOF && k <= KUN) begin
                ok = (k == KSOF) ? sie : (k == KEOF) ? eie : 1'b1;
                if (ok) begin
                    pb = (k == KSOF) ? 1 : (k == KEOF) ? 8 : (k == KBR) ? 9 : 4;
                    sb = ((k == KSOF) ? 0 : (k == KEOF) ? 8 : (k == KBR) ? 16 : 24) + ch - 1;
                    if (ch == 0) begin n0[pb] = 1'b1; unm = !m_ctrl[16 + pb]; end
                    else begin n1[sb] = 1'b1; unm = !m_mask[sb]; end
                    cap = unm && (k != KUN);
                end
            end
        end
        if (cap) begin
            if (m_irq) n0[10] = 1'b1;
            else ni = id;
        end
        @(posedge clk);
        m_st0 = n0; m_st1 = n1; m_ctrl = nc; m_mask = nm; m_id = ni; m_irq = nirq;
        #1;
        ev_valid = 0; reg_we = 0;
        compare();
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic ev(input int k, input int ch, input logic [31:0] id);
        step(1, k, ch, 1, 1, id, 0, 0, 0);
    endtask
    task automatic wr(input int a, input logic [31:0] d); step(0, 0, 0, 0, 0, 0, 1, a, d); endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; ev_valid = 0; ev_kind = 0; ev_ch = 0; ev_sof_ie = 0; ev_eof_ie = 0;
        ev_id = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        m_ctrl = 0; m_mask = 0; m_st0 = 0; m_st1 = 0; m_id = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        cur_req = "R1"; compare();

        // R2 R5: ch0 start-of-frame while line low captures the ID
        cur_req = "R2/R5"; ev(KSOF, 0, 32'hA000_0001);
        cur_req = "R4"; idle();
        // R6: start-of-frame on ch3 with the line high
        cur_req = "R6"; ev(KSOF, 3, 32'hB000_0003);
        // R3: enable copies low
        cur_req = "R3"; step(1, KSOF, 2, 0, 1, 32'hDEAD_0002, 0, 0, 0);
        step(1, KEOF, 4, 1, 0, 32'hDEAD_0004, 0, 0, 0);
        // R2: remaining groups on several channels
        cur_req = "R2"; ev(KEOF, 6, 32'h6); ev(KBR, 1, 32'h1); ev(KUN, 4, 32'h4);
        ev(KEOF, 0, 32'h10); ev(KBR, 0, 32'h11); ev(KUN, 0, 32'h12); ev(KFD, 5, 32'h13);
        // R8 R9: clear everything clearable
        cur_req = "R8/R9"; wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF); idle();
        // R13 R4: masking the sticky leftovers drops the line
        cur_req = "R13/R4"; wr(1, 32'hFFFF_FFFF); idle(); idle();
        wr(0, 32'hFFFF_FFFF); idle();
        // R5: masked ch0 end-of-frame sets status, no capture
        cur_req = "R5"; ev(KEOF, 0, 32'hCCCC_0000); idle();
        // R7: bus errors under full masking
        cur_req = "R7"; ev(KBER, 5, 32'hE005); ev(KBER, 2, 32'hE002); idle();
        // R8: clearing bit 2 wipes the channel field
        cur_req = "R8"; wr(2, 32'h0000_0004); idle();
        // R10: enable 1 -> 0
        cur_req = "R10"; wr(0, 32'h0000_0001); wr(0, 32'h0000_0000); idle();
        // R11: event and clear of the same bit together
        cur_req = "R11"; wr(2, 32'hFFF); idle(); idle();
        step(1, KSOF, 0, 1, 1, 32'h1111, 1, 2, 32'h0000_0002); idle();
        // R12: channel 7 ignored, underrun never captures
        cur_req = "R12"; wr(2, 32'hFFF); wr(3, 32'hFFFF_FFFF); wr(1, 0); idle(); idle();
        ev(KSOF, 7, 32'h7777); ev(KBER, 7, 32'h7778); ev(KUN, 0, 32'h5555); idle();

        // mixed traffic
        cur_req = "R2-mix";
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom);
            int kk = (r >> 3) % 7;
            int cc = (r >> 6) % 8;
            bit w = ((r >> 9) % 5) == 0;
            int aa = (r >> 12) % 5;
            logic [31:0] d = $urandom;
            if (((r >> 15) % 3) == 0) d = 32'hFFFF_FFFF;
            step(((r >> 17) % 2) == 1, kk, cc, r[20], r[21], $urandom, w, aa, d);
        end
        finish_run();
    end

endmodule